// File: doc/BRIEF.md
# Shared Prescaler and Per-Channel Clock Select

This block turns one free-running prescaler into count-enable pulses for several timer channels. Each channel picks its own rate with a 3-bit select code. The choices are: stopped, every system cycle, one of four divided taps, or edges of an external clock pin that is synchronized and edge-detected in the system clock domain. Every enable is a single system-clock-cycle pulse that a timer counter uses as its increment qualifier. The block contains no second clock domain.

The prescaler runs no matter which code any channel selects. A channel moved onto a divided tap therefore picks up the current phase of the shared counter, and its first enable can arrive anywhere within one tap period. A synchronous clear input restarts the shared counter. This aligns the tap phase to a known point, and it does so for every channel that uses a divided rate.

The number of channels, the four tap exponents and the depth of the synchronizer are parameters.

Top module: `tcs_clk_select`

## Requirements
- R1: Select code 0 gives no enable on that channel in any cycle.
- R2: Select code 1 gives an enable on that channel in every cycle, including the cycle in which the prescaler is cleared.
- R3: Select codes 2, 3, 4 and 5 give a one-cycle enable in each cycle in which the low 3, 6, 8 or 10 bits of the prescaler count are all ones. The resulting periods are 8, 64, 256 and 1024 cycles.
- R4: After each clock edge the prescaler count is one higher than before, modulo 1024, unless a clear was asserted. Select codes and pin activity never alter this count or its phase.
- R5: After a channel moves from code 0 to a divided tap of divisor N, its first enable comes within 1 to N+1 cycles. The cycle in which the new code is applied counts as cycle 1.
- R6: While the clear input is high, no divided-tap enable is produced. The count is zero after that clock edge, so the next divide-by-N enable on every channel follows N cycles after the clear cycle.
- R7: Select code 7 gives one enable per rising edge of the channel's pin. The enable is high during the cycle that follows the second rising clock edge at which the new pin level is sampled.
- R8: Select code 6 gives one enable per falling edge of the channel's pin, with the same timing as R7.
- R9: A pin that holds its level for three or more cycles gives no enable under code 6 or 7. This also holds when the channel switches to such a code while the pin is already high.
- R10: Channels are independent: each channel's enable depends only on its own select code and pin and on the shared prescaler.
- R11: While the active-low asynchronous reset is asserted, the prescaler count and all synchronizer stages are zero. With every select code 0 to 5, no divided-tap enable appears during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps_clear | input | 1 | Synchronous restart of the shared prescaler |
| ch_sel | input | 3*NUM_CH | Select codes, channel i in bits [3i+2:3i] |
| ext_clk | input | NUM_CH | External clock pin per channel, asynchronous |
| cnt_en | output | NUM_CH | One-cycle count enable per channel |

## Verification
A wrong prescaler value shows on every divided-tap channel as an enable in the wrong cycle. For divide-by-8 this appears within eight cycles, but for divide-by-1024 it can stay hidden for a thousand cycles. For that reason the bench compares the output every cycle against a phase model from reset and from each clear. A fault in a synchronizer stage moves the pin-driven enable by a cycle or flips its edge polarity, and this shows at the first pin transition. Select decode faults show in the first cycle the affected code is applied.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
   localparam int unsigned SEL_W    = 3;
   localparam int unsigned NUM_TAPS = 4;

   typedef enum logic [SEL_W-1:0] {
      CS_STOP     = 3'd0,
      CS_SYS      = 3'd1,
      CS_TAP0     = 3'd2,
      CS_TAP1     = 3'd3,
      CS_TAP2     = 3'd4,
      CS_TAP3     = 3'd5,
      CS_EXT_FALL = 3'd6,
      CS_EXT_RISE = 3'd7
   } clk_sel_e;
endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
   parameter int unsigned CNT_W = 10,
   parameter int unsigned EXP0  = 3,
   parameter int unsigned EXP1  = 6,
   parameter int unsigned EXP2  = 8,
   parameter int unsigned EXP3  = 10
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clear,
   output logic [tcs_pkg::NUM_TAPS-1:0]    tap_pulse,
   output logic [CNT_W-1:0]                count
);
   localparam int unsigned TAP_EXP [tcs_pkg::NUM_TAPS] = '{EXP0, EXP1, EXP2, EXP3};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clear) count <= '0;
      else            count <= count + 1'b1;
   end

   // one tap per exponent: fires on the last count before its low bits wrap
   for (genvar t = 0; t < int'(tcs_pkg::NUM_TAPS); t++) begin : g_tap
      localparam int unsigned E = TAP_EXP[t];
      assign tap_pulse[t] = (&count[E-1:0]) & ~clear;
   end
endmodule

// File: rtl/tcs_edge_sync.sv
module tcs_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~prev_q;
   assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tcs_chan_sel.sv
module tcs_chan_sel (
   input  logic [tcs_pkg::SEL_W-1:0]    sel,
   input  logic [tcs_pkg::NUM_TAPS-1:0] taps,
   input  logic                         pin_rise,
   input  logic                         pin_fall,
   output logic                         en
);
   import tcs_pkg::*;

   always_comb begin
      unique case (clk_sel_e'(sel))
         CS_STOP:     en = 1'b0;
         CS_SYS:      en = 1'b1;
         CS_TAP0:     en = taps[0];
         CS_TAP1:     en = taps[1];
         CS_TAP2:     en = taps[2];
         CS_TAP3:     en = taps[3];
         CS_EXT_FALL: en = pin_fall;
         CS_EXT_RISE: en = pin_rise;
         default:     en = 1'b0;
      endcase
   end
endmodule

// File: rtl/tcs_clk_select.sv
module tcs_clk_select #(
   parameter int unsigned NUM_CH      = 3,
   parameter int unsigned TAP0_LOG2   = 3,
   parameter int unsigned TAP1_LOG2   = 6,
   parameter int unsigned TAP2_LOG2   = 8,
   parameter int unsigned TAP3_LOG2   = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 ps_clear,
   input  logic [NUM_CH*tcs_pkg::SEL_W-1:0]     ch_sel,
   input  logic [NUM_CH-1:0]                    ext_clk,
   output logic [NUM_CH-1:0]                    cnt_en
);
   localparam int unsigned CNT_W = TAP3_LOG2;
   localparam int unsigned SW    = tcs_pkg::SEL_W;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("tcs_clk_select: NUM_CH must be at least 1");
   end
   if (!(TAP0_LOG2 >= 1 && TAP0_LOG2 < TAP1_LOG2 && TAP1_LOG2 < TAP2_LOG2 &&
         TAP2_LOG2 < TAP3_LOG2 && TAP3_LOG2 <= 24)) begin : g_bad_tap
      $error("tcs_clk_select: tap exponents must rise strictly, up to 24");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tcs_clk_select: SYNC_STAGES must be at least 2");
   end

   logic [tcs_pkg::NUM_TAPS-1:0] taps;
   logic [CNT_W-1:0]             ps_count;

   tcs_prescaler #(
      .CNT_W (CNT_W),
      .EXP0  (TAP0_LOG2),
      .EXP1  (TAP1_LOG2),
      .EXP2  (TAP2_LOG2),
      .EXP3  (TAP3_LOG2)
   ) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (ps_clear),
      .tap_pulse (taps),
      .count     (ps_count)
   );

   for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_ch
      logic rise, fall;

      tcs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .pin   (ext_clk[i]),
         .rise  (rise),
         .fall  (fall)
      );

      tcs_chan_sel u_sel (
         .sel      (ch_sel[i*SW +: SW]),
         .taps     (taps),
         .pin_rise (rise),
         .pin_fall (fall),
         .en       (cnt_en[i])
      );
   end
endmodule

// File: rtl/tcs_clk_select_chk.sv
module tcs_clk_select_chk #(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned CNT_W  = 10
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    ps_clear,
   input logic [NUM_CH*3-1:0]     ch_sel,
   input logic [NUM_CH-1:0]       ext_clk,
   input logic [NUM_CH-1:0]       cnt_en,
   input logic [CNT_W-1:0]        ps_count
);
   logic [2:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             age_q <= '0;
      else if (age_q != 3'd7) age_q <= age_q + 3'd1;
   end

   // R6
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ps_clear |=> (ps_count == '0));

   // R4
   free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ps_clear |=> (ps_count == CNT_W'($past(ps_count) + 1'b1)));

   for (genvar i = 0; i < int'(NUM_CH); i++) begin : g_ch
      logic [2:0] s;
      assign s = ch_sel[i*3 +: 3];

      // R1
      stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (s == 3'd0) |-> !cnt_en[i]);

      // R2
      sys_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (s == 3'd1) |-> cnt_en[i]);

      // R3
      tap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (s >= 3'd2 && s <= 3'd5 && cnt_en[i]) |=> (s != $past(s) || !cnt_en[i]));

      // R7
      ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (s >= 3'd6 && cnt_en[i]) |=> (s != $past(s) || !cnt_en[i]));

      // R9
      ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (age_q >= 3'd4 && s >= 3'd6 &&
          ext_clk[i] == $past(ext_clk[i]) &&
          ext_clk[i] == $past(ext_clk[i], 2) &&
          ext_clk[i] == $past(ext_clk[i], 3)) |-> !cnt_en[i]);
   end
endmodule

bind tcs_clk_select tcs_clk_select_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ps_clear (ps_clear),
   .ch_sel   (ch_sel),
   .ext_clk  (ext_clk),
   .cnt_en   (cnt_en),
   .ps_count (ps_count)
);

// File: tb/tcs_clk_select_tb.sv
module tcs_clk_select_tb;
   localparam int NCH = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ps_clear = 1'b0;
   logic [NCH*3-1:0] ch_sel = '0;
   logic [NCH-1:0] ext_clk = '0;
   logic [NCH-1:0] cnt_en;

   int n_chk = 0;
   int n_fail = 0;

   // model state, advanced at each rising edge
   int             pc = 0;
   logic [NCH-1:0] m1 = '0, m2 = '0, m3 = '0;
   logic [NCH-1:0] exp_q [$];

   always #2 clk = ~clk;

   tcs_clk_select u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .ps_clear (ps_clear),
      .ch_sel   (ch_sel),
      .ext_clk  (ext_clk),
      .cnt_en   (cnt_en)
   );

   function automatic string req_of(input logic [2:0] c);
      case (c)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd6: return "R8";
         3'd7: return "R7";
         default: return "R3";
      endcase
   endfunction

   function automatic logic [NCH-1:0] expected();
      logic [NCH-1:0] e;
      for (int i = 0; i < NCH; i++) begin
         logic [2:0] c;
         c = ch_sel[i*3 +: 3];
         case (c)
            3'd0: e[i] = 1'b0;
            3'd1: e[i] = 1'b1;
            3'd2: e[i] = ((pc % 8)    == 7)    && !ps_clear;
            3'd3: e[i] = ((pc % 64)   == 63)   && !ps_clear;
            3'd4: e[i] = ((pc % 256)  == 255)  && !ps_clear;
            3'd5: e[i] = ((pc % 1024) == 1023) && !ps_clear;
            3'd6: e[i] = !m2[i] && m3[i];
            default: e[i] = m2[i] && !m3[i];
         endcase
      end
      return e;
   endfunction

   // driver: one cycle, new inputs applied just after the edge
   task automatic step(input logic [NCH*3-1:0] s, input logic [NCH-1:0] p, input logic c);
      @(posedge clk);
      if (!rst_n) begin
         pc = 0; m1 = '0; m2 = '0; m3 = '0;
      end else begin
         pc = ps_clear ? 0 : (pc + 1) % 1024;
         m3 = m2; m2 = m1; m1 = ext_clk;
      end
      #1;
      ch_sel = s; ext_clk = p; ps_clear = c;
      exp_q.push_back(expected());
   endtask

   task automatic hold(input int n);
      for (int k = 0; k < n; k++) step(ch_sel, ext_clk, 1'b0);
   endtask

   // monitor: compares at the falling edge
   always @(negedge clk) begin
      if (exp_q.size() != 0) begin
         logic [NCH-1:0] e;
         e = exp_q.pop_front();
         n_chk++;
         if (cnt_en !== e) begin
            n_fail++;
            for (int i = 0; i < NCH; i++)
               if (cnt_en[i] !== e[i])
                  $display("FAIL %s ch%0d code %0d: actual=%b expected=%b", req_of(ch_sel[i*3 +: 3]),
                           i, ch_sel[i*3 +: 3], cnt_en[i], e[i]);
         end
      end
   end

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      int lat;
      // R11: reset state with divided taps selected
      ch_sel = {3'd5, 3'd3, 3'd2};
      ext_clk = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_chk++;
      if (cnt_en !== '0) begin
         n_fail++;
         $display("FAIL R11 reset: actual=%b expected=000", cnt_en);
      end
      @(posedge clk); #1; rst_n = 1'b1;
      // R3/R10: three channels on three different taps
      hold(300);
      // R5: ch0 stopped, then moved to divide-by-256 at an arbitrary phase
      step({3'd3, 3'd1, 3'd0}, '0, 1'b0);
      hold(37);
      step({3'd3, 3'd1, 3'd4}, '0, 1'b0);
      lat = 1;
      #1;
      while (!cnt_en[0] && lat < 400) begin
         step(ch_sel, ext_clk, 1'b0);
         lat++;
         #1;
      end
      n_chk++;
      if (lat < 1 || lat > 257) begin
         n_fail++;
         $display("FAIL R5 first tap enable latency: actual=%0d expected=1..257", lat);
      end
      // R4: ch1 select codes churn while ch0 stays on divide-by-8
      step({3'd3, 3'd0, 3'd2}, '0, 1'b0);
      for (int k = 0; k < 40; k++) begin
         logic [2:0] c;
         c = 3'(k % 6);
         step({3'd3, c, 3'd2}, '0, 1'b0);
      end
      // R6: clear mid-period, codes 2, 3 and 1 (R2) in the clear cycle
      hold(5);
      step({3'd1, 3'd3, 3'd2}, '0, 1'b1);
      hold(150);
      step({3'd1, 3'd3, 3'd2}, '0, 1'b1);
      step({3'd1, 3'd3, 3'd2}, '0, 1'b1);
      hold(20);
      // R3: divide-by-1024 over two full periods
      step({3'd5, 3'd5, 3'd5}, '0, 1'b0);
      hold(2100);
      // R7/R8/R9: pins slow, fast, and high-held when switching
      step({3'd6, 3'd7, 3'd0}, '0, 1'b0);
      for (int k = 0; k < 60; k++)
         step(ch_sel, {NCH{1'b0}} | {1'b0, 1'b0, 1'b0} | NCH'((k / 5) % 2 ? 3'b110 : 3'b000), 1'b0);
      for (int k = 0; k < 30; k++)
         step(ch_sel, NCH'((k % 2) ? 3'b111 : 3'b000), 1'b0);
      step({3'd0, 3'd0, 3'd0}, 3'b111, 1'b0);
      hold(6);
      // R9: switch onto edge codes while pins are steadily high
      step({3'd6, 3'd7, 3'd7}, 3'b111, 1'b0);
      hold(10);
      // R10: mixed codes with independent pin patterns
      step({3'd7, 3'd6, 3'd1}, 3'b000, 1'b0);
      for (int k = 0; k < 50; k++)
         step(ch_sel, {1'(k % 3 == 0), 1'(k % 4 < 2), 1'(k % 2)}, 1'b0);
      hold(3);
      @(posedge clk); @(posedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule